// File: doc/BRIEF.md
# Shared Bus Ownership Arbiter

This block decides which of up to four processors owns a single shared external bus. Every processor raises its own request line. The arbiter returns a grant vector that is either one-hot or all-zero. The same arbiter is placed in every processor on the bus, and all copies see the same request lines. Because the logic is fully deterministic and has only synchronous state, every copy reaches the same decision on the same clock edge. No central arbiter is needed.

A static mode input selects one of two priority schemes. In fixed mode the lowest-numbered master always wins. In rotating mode the search starts just after the master that most recently gave up the bus. The current owner can assert a lock input to keep the bus even after it lowers its request. A hold timer is loaded from a programmable limit each time a grant is issued. When the timer has run out and another master is waiting, the timer takes the bus back, even if the lock is asserted, and raises a one-cycle flag.

Top module: `shbus_arbiter`

## Requirements
- R1: While reset is asserted, and directly after it, `bus_grant` is zero and `tout_flag` is low. The rotation start is set so that master 0 (bit 0) has the highest priority in rotating mode.
- R2: `bus_grant` is always one-hot or zero. A new grant goes only to a master whose request was high at the edge that produced the grant.
- R3: With `rotate_en` low (fixed mode), when the bus is free the lowest-indexed requesting master wins. Bit 0 has the highest priority and bit 3 the lowest.
- R4: With `rotate_en` high, the search order starts at the index one above the last releasing master and wraps after the top index. The releasing master therefore has the lowest priority in the next arbitration.
- R5: The owner keeps its grant on every edge at which its request is still high, unless a time-out fires.
- R6: When the owner's request is low and `bus_lock` is low at an edge, the grant drops to zero for exactly one cycle. The next edge arbitrates among the requests present at that edge.
- R7: While `bus_lock` is high, the owner keeps the grant even when its own request is low, and no other master is granted.
- R8: Each new grant loads the timer with `hold_limit`. On each later edge the timer counts down by one until it reaches zero. If another master is requesting at an edge where the timer is zero, the grant drops to zero at that edge, even if `bus_lock` is high. `tout_flag` is high for that one following cycle only. With a limit of L, the revoke happens at the (L+1)th edge after the grant edge.
- R9: When the timer is zero but no other master is requesting, the owner keeps the bus.
- R10: Two instances that receive identical inputs produce identical `bus_grant` and `tout_flag` on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | N_MASTERS | One request line per master, bit i for master i |
| bus_lock | input | 1 | Owner asks to keep the bus |
| rotate_en | input | 1 | 0 selects fixed priority, 1 selects rotating priority |
| hold_limit | input | TOUT_W | Timer value loaded at each new grant |
| bus_grant | output | N_MASTERS | One-hot or zero grant vector |
| tout_flag | output | 1 | One-cycle pulse when a tenure is ended by the timer |

## Verification
A wrong rotation pointer does not show up until the next contested arbitration in rotating mode. At that point the wrong master is granted one edge after the idle gap. A timer that is loaded or decremented wrongly moves the revoke edge and the flag pulse away from edge L+1. A lost lock or a lost owner match shows up as the grant dropping one edge too early. The bench therefore samples the grant one cycle after each edge, and it runs a second copy alongside the first so that any divergence between copies is caught in the same cycle.

// File: rtl/shbus_pkg.sv
package shbus_pkg;
  typedef enum logic { PRIO_FIXED = 1'b0, PRIO_ROTATE = 1'b1 } prio_mode_e;

  // Index after v, wrapping at n.
  function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction
endpackage

// File: rtl/shbus_prio_pick.sv
module shbus_prio_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] start,
  output logic [N-1:0]  win
);
  always_comb begin
    logic found;
    int   idx;
    win   = '0;
    found = 1'b0;
    for (int k = 0; k < N; k++) begin
      idx = (int'(start) + k) % N;
      if (!found && req[idx]) begin
        win[idx] = 1'b1;
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/shbus_hold_timer.sv
module shbus_hold_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         at_zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (load)               cnt_q <= limit;
    else if (run && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign at_zero = (cnt_q == '0);
endmodule

// File: rtl/shbus_arbiter.sv
module shbus_arbiter
  import shbus_pkg::*;
#(
  parameter int N_MASTERS = 4,
  parameter int TOUT_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_MASTERS-1:0] bus_req,
  input  logic                 bus_lock,
  input  logic                 rotate_en,
  input  logic [TOUT_W-1:0]    hold_limit,
  output logic [N_MASTERS-1:0] bus_grant,
  output logic                 tout_flag
);
  localparam int IW = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1;

  logic [N_MASTERS-1:0] grant_q, pick;
  logic [IW-1:0]        last_q, start_idx, owner_idx;
  logic                 tout_q;

  // Named internal events, brought out for the checker.
  logic bus_busy, owner_req, competitor, release_ev, tout_fire, new_grant, cnt_zero;

  assign bus_busy   = (grant_q != '0);
  assign owner_req  = |(bus_req & grant_q);
  assign competitor = |(bus_req & ~grant_q);
  assign release_ev = bus_busy && !owner_req && !bus_lock;
  assign tout_fire  = bus_busy && cnt_zero && competitor && !release_ev;
  assign new_grant  = !bus_busy && (bus_req != '0);

  assign start_idx = (prio_mode_e'(rotate_en) == PRIO_ROTATE)
                   ? IW'(wrap_inc(int'(last_q), N_MASTERS)) : '0;

  always_comb begin
    owner_idx = '0;
    for (int k = 0; k < N_MASTERS; k++)
      if (grant_q[k]) owner_idx = IW'(k);
  end

  shbus_prio_pick #(.N(N_MASTERS), .IW(IW)) u_pick (
    .req   (bus_req),
    .start (start_idx),
    .win   (pick)
  );

  shbus_hold_timer #(.W(TOUT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (new_grant),
    .run     (bus_busy),
    .limit   (hold_limit),
    .at_zero (cnt_zero)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_q <= '0;
      last_q  <= IW'(N_MASTERS - 1);
      tout_q  <= 1'b0;
    end else begin
      tout_q <= tout_fire;
      if (release_ev || tout_fire) begin
        grant_q <= '0;
        last_q  <= owner_idx;
      end else if (new_grant) begin
        grant_q <= pick;
      end
    end
  end

  assign bus_grant = grant_q;
  assign tout_flag = tout_q;
endmodule

// File: rtl/shbus_arbiter_chk.sv
module shbus_arbiter_chk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] bus_req,
  input logic         bus_lock,
  input logic [N-1:0] bus_grant,
  input logic         tout_flag,
  input logic         tout_fire,
  input logic         cnt_zero
);
  a_r2_grant_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_grant));

  a_r2_grant_to_requester: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_grant) == '0 && bus_grant != '0) |-> (($past(bus_req) & bus_grant) != '0));

  a_r6_no_direct_handoff: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_grant != '0) |=> (bus_grant == '0 || $stable(bus_grant)));

  a_r7_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_grant != '0 && bus_lock && !tout_fire) |=> $stable(bus_grant));

  a_r8_tout_revokes: assert property (@(posedge clk) disable iff (!rst_n)
    tout_fire |=> (bus_grant == '0 && tout_flag));

  a_r8_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
    tout_flag |-> ($past(bus_grant) != '0 && $past(cnt_zero) && bus_grant == '0));

  a_r8_flag_single: assert property (@(posedge clk) disable iff (!rst_n)
    tout_flag |=> !tout_flag);
endmodule

bind shbus_arbiter shbus_arbiter_chk #(.N(N_MASTERS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_req   (bus_req),
  .bus_lock  (bus_lock),
  .bus_grant (bus_grant),
  .tout_flag (tout_flag),
  .tout_fire (tout_fire),
  .cnt_zero  (cnt_zero)
);

// File: tb/shbus_arbiter_bench.sv
module shbus_arbiter_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_req = '0;
  logic       bus_lock = 1'b0;
  logic       rotate_en = 1'b0;
  logic [7:0] hold_limit = 8'd200;
  logic [3:0] bus_grant, peer_grant;
  logic       tout_flag, peer_tout;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  shbus_arbiter u_shbus_arbiter (.clk, .rst_n, .bus_req, .bus_lock, .rotate_en,
    .hold_limit, .bus_grant, .tout_flag);
  shbus_arbiter u_peer (.clk, .rst_n, .bus_req, .bus_lock, .rotate_en,
    .hold_limit, .bus_grant(peer_grant), .tout_flag(peer_tout));

  // {rotate_en, bus_lock, bus_req[3:0], expected grant[3:0]}
  localparam logic [9:0] VEC [0:21] = '{
    {1'b0,1'b0,4'b0000,4'b0000}, // R2 nothing requested
    {1'b0,1'b0,4'b1010,4'b0010}, // R3 lowest index wins
    {1'b0,1'b0,4'b1011,4'b0010}, // R5 owner keeps
    {1'b0,1'b0,4'b1001,4'b0000}, // R6 release gap
    {1'b0,1'b0,4'b1001,4'b0001}, // R3
    {1'b0,1'b0,4'b1000,4'b0000}, // R6
    {1'b0,1'b0,4'b1000,4'b1000}, // R3
    {1'b0,1'b0,4'b0000,4'b0000}, // R6
    {1'b1,1'b0,4'b1111,4'b0001}, // R4 start after 3 -> 0
    {1'b1,1'b0,4'b1110,4'b0000}, // R6
    {1'b1,1'b0,4'b1110,4'b0010}, // R4
    {1'b1,1'b0,4'b1101,4'b0000}, // R6
    {1'b1,1'b0,4'b1101,4'b0100}, // R4
    {1'b1,1'b0,4'b1011,4'b0000}, // R6
    {1'b1,1'b0,4'b1011,4'b1000}, // R4
    {1'b1,1'b0,4'b0011,4'b0000}, // R6
    {1'b1,1'b0,4'b0011,4'b0001}, // R4 wrap to 0
    {1'b1,1'b1,4'b0010,4'b0001}, // R7 locked, own request low
    {1'b1,1'b1,4'b0110,4'b0001}, // R7
    {1'b1,1'b0,4'b0110,4'b0000}, // R6 unlock releases
    {1'b1,1'b0,4'b0110,4'b0010}, // R4
    {1'b1,1'b0,4'b0000,4'b0000}  // R6
  };
  localparam int TAG [0:21] = '{2,3,5,6,3,6,3,6,4,6,4,6,4,6,4,6,4,7,7,6,4,6};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_out(input string tag, input logic [3:0] g, input logic f);
    chk(tag, bus_grant, g);
    chk(tag, tout_flag, f);
    chk("R10", {peer_tout, peer_grant}, {tout_flag, bus_grant});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_out("R1", 4'b0000, 1'b0);
    rst_n = 1'b1;
    for (int i = 0; i < 22; i++) begin
      rotate_en = VEC[i][9];
      bus_lock  = VEC[i][8];
      bus_req   = VEC[i][7:4];
      @(negedge clk);
      chk_out($sformatf("R%0d", TAG[i]), VEC[i][3:0], 1'b0);
    end

    // R8: time-out with limit 3 overrides lock
    rotate_en = 1'b0; hold_limit = 8'd3; bus_req = 4'b0001;
    @(negedge clk); chk_out("R3", 4'b0001, 1'b0);
    bus_req = 4'b0011; bus_lock = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); chk_out("R8", 4'b0001, 1'b0);
    end
    @(negedge clk); chk_out("R8", 4'b0000, 1'b1);
    @(negedge clk); chk_out("R8", 4'b0001, 1'b0);

    // R9: timer expires with no competitor
    bus_req = 4'b0001; bus_lock = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); chk_out("R9", 4'b0001, 1'b0);
    end
    bus_req = 4'b0000;
    @(negedge clk); chk_out("R6", 4'b0000, 1'b0);

    // R8: limit 0 revokes on the first edge after the grant
    hold_limit = 8'd0; bus_req = 4'b0100;
    @(negedge clk); chk_out("R3", 4'b0100, 1'b0);
    bus_req = 4'b0110;
    @(negedge clk); chk_out("R8", 4'b0000, 1'b1);
    @(negedge clk); chk_out("R3", 4'b0010, 1'b0);

    // R1: reset mid-run restores pointer
    hold_limit = 8'd200; rst_n = 1'b0;
    @(negedge clk); chk_out("R1", 4'b0000, 1'b0);
    rst_n = 1'b1; rotate_en = 1'b1; bus_req = 4'b1111;
    @(negedge clk); chk_out("R1", 4'b0001, 1'b0);

    finish_run();
  end
endmodule